// File: doc/BRIEF.md
# Byte-Link Status and Control Register Pair

This block sits between the receive/transmit logic of a byte-level serial vehicle-bus interface and the host. The symbol decoder and the transmitter report events as single-cycle strobes: a CRC mismatch, any of several framing, symbol, echo or host-protocol errors, and the first rising bus edge after a break symbol. These events are latched into sticky flags. They are presented to the host as an 8-bit status byte during a status/control exchange. The exchange is bracketed by a start strobe and a completion strobe. The status byte is captured at the start strobe. At completion, exactly the flags that were reported in that capture are cleared.

The block also holds the 8-bit control byte written by the host. The upper four control bits can only be set by the host and are cleared only by hardware-clear requests. The lower four bits can be written freely. Bit 3 of these selects the 4x speed mode. A separate mode output passes that bit to the decoder only when a bus edge is signalled. A break's trailing edge forces both the speed-mode bit and the active mode back to normal speed.

Top module: `bic_stat_ctrl`

## Requirements
- R1: Status bits 7, 6 and 5 always read 0. The other positions are: bit 4 first-time-up, bit 3 speed-mode mirror, bit 2 CRC error, bit 1 general error, bit 0 break.
- R2: Status bit 4 is 1 in every status capture taken before the first completion strobe after reset, and 0 in every capture after that.
- R3: A pulse on `ev_crc_err` sets the CRC flag from the next cycle. The flag stays set until it is cleared as described in R7.
- R4: A pulse on any bit of `ev_err_src` sets the general error flag from the next cycle.
- R5: A pulse on `ev_brk_rise` sets the break flag from the next cycle.
- R6: `stat_byte` is loaded on the clock edge where `xfer_start` is high, with the flags registered before that edge. It then holds until the next start strobe, even if new events occur in between.
- R7: A completion strobe clears exactly those flags that read 1 in the current `stat_byte`. A flag set after the capture survives and appears in the next exchange.
- R8: When a flag's set strobe and its clear by completion fall in the same cycle, the flag stays set.
- R9: The control byte is ACK(7), MACK(6), NXT(5), PD(4), 4X(3), DS2..DS0(2:0). A write on `ctrl_wr` loads bits 3:0 from `ctrl_wdata` as given, both ones and zeros.
- R10: On bits 7:4, a written 1 sets the bit and a written 0 has no effect. `hw_clr[i]` clears bit i, and takes precedence over a set in the same cycle. `hw_clr` has no effect on bits 3:0.
- R11: Status bit 3 copies control bit 3. `brk_trail` clears control bit 3, and takes precedence over a same-cycle write of 1.
- R12: `mode_4x` takes the registered value of control bit 3 only on a cycle with `bus_edge` high. At other times it holds. `brk_trail` clears it.
- R13: After reset, `stat_byte`, `ctrl_byte` and `mode_4x` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_crc_err | input | 1 | CRC error event strobe |
| ev_err_src | input | N_ERR_SRC | General error event strobes, one per source |
| ev_brk_rise | input | 1 | First rising bus edge after a break |
| brk_trail | input | 1 | Break trailing-edge strobe |
| xfer_start | input | 1 | Status/control exchange start |
| xfer_done | input | 1 | Status/control exchange completion |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte from the host |
| hw_clr | input | 8 | Hardware clear request per control bit |
| bus_edge | input | 1 | Bus input edge seen by the decoder |
| stat_byte | output | 8 | Status byte presented to the host |
| ctrl_byte | output | 8 | Current control byte |
| mode_4x | output | 1 | Speed mode applied by the decoder |

## Verification
Every result is a single register stage away from its stimulus. Flags, control bits and `mode_4x` change on the first clock edge where the strobe is high. `stat_byte` changes on the start-strobe edge, and a flag cleared by completion is visible only in the capture taken at the next start. The bench drives strobes one time unit after a rising edge, lets exactly one edge pass, and samples one time unit after that edge. Reporting that crosses exchanges is checked through a second start capture, not through internal state.

// File: rtl/bic_sc_pkg.sv
package bic_sc_pkg;
   localparam int STAT_W = 8;
   localparam int CTRL_W = 8;
   localparam int ST_BRK = 0;
   localparam int ST_ERR = 1;
   localparam int ST_CRC = 2;
   localparam int ST_X4  = 3;
   localparam int ST_FTU = 4;
   localparam int CT_X4  = 3;
   localparam logic [CTRL_W-1:0] DEF_SET_ONLY = 8'hF0;
endpackage

// File: rtl/bic_flag_cell.sv
module bic_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/bic_ctrl_reg.sv
module bic_ctrl_reg #(
   parameter int           W             = 8,
   parameter logic [W-1:0] SET_ONLY_MASK = 8'hF0,
   parameter int           X4_BIT        = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] hw_clr_i,
   input  logic         brk_trail_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] so_next;
   logic [W-1:0] rw_next;
   logic [W-1:0] d;

   always_comb begin
      so_next = (q_o | ({W{wr_i}} & wdata_i)) & ~hw_clr_i;
      rw_next = wr_i ? wdata_i : q_o;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (SET_ONLY_MASK[i]) begin : g_set_only
         assign d[i] = so_next[i];
      end else if (i == X4_BIT) begin : g_speed
         assign d[i] = rw_next[i] & ~brk_trail_i;
      end else begin : g_rw
         assign d[i] = rw_next[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d;
   end
endmodule

// File: rtl/bic_stat_snap.sv
module bic_stat_snap #(
   parameter int W        = 8,
   parameter bit SNAPSHOT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] live_i,
   output logic [W-1:0] stat_o
);
   if (SNAPSHOT) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       stat_o <= '0;
         else if (start_i) stat_o <= live_i;
      end
   end else begin : g_live
      assign stat_o = live_i;
   end
endmodule

// File: rtl/bic_stat_ctrl.sv
module bic_stat_ctrl
   import bic_sc_pkg::*;
#(
   parameter int                N_ERR_SRC     = 5,
   parameter logic [CTRL_W-1:0] SET_ONLY_MASK = DEF_SET_ONLY,
   parameter bit                SNAPSHOT      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_crc_err,
   input  logic [N_ERR_SRC-1:0] ev_err_src,
   input  logic                 ev_brk_rise,
   input  logic                 brk_trail,
   input  logic                 xfer_start,
   input  logic                 xfer_done,
   input  logic                 ctrl_wr,
   input  logic [CTRL_W-1:0]    ctrl_wdata,
   input  logic [CTRL_W-1:0]    hw_clr,
   input  logic                 bus_edge,
   output logic [STAT_W-1:0]    stat_byte,
   output logic [CTRL_W-1:0]    ctrl_byte,
   output logic                 mode_4x
);
   if (N_ERR_SRC < 1) begin : g_bad_src
      $error("bic_stat_ctrl: N_ERR_SRC must be at least 1");
   end
   if (SET_ONLY_MASK[CT_X4]) begin : g_bad_mask
      $error("bic_stat_ctrl: speed-mode bit must stay host-writable");
   end

   logic crc_q, err_q, brk_q, ftu_q;
   logic [STAT_W-1:0] live;
   logic [STAT_W-1:0] clr_mask;

   assign clr_mask = {STAT_W{xfer_done}} & stat_byte;

   bic_flag_cell #(.RST_VAL(1'b0)) u_crc (
      .clk(clk), .rst_n(rst_n), .set_i(ev_crc_err),
      .clr_i(clr_mask[ST_CRC]), .q_o(crc_q));

   bic_flag_cell #(.RST_VAL(1'b0)) u_err (
      .clk(clk), .rst_n(rst_n), .set_i(|ev_err_src),
      .clr_i(clr_mask[ST_ERR]), .q_o(err_q));

   bic_flag_cell #(.RST_VAL(1'b0)) u_brk (
      .clk(clk), .rst_n(rst_n), .set_i(ev_brk_rise),
      .clr_i(clr_mask[ST_BRK]), .q_o(brk_q));

   bic_flag_cell #(.RST_VAL(1'b1)) u_ftu (
      .clk(clk), .rst_n(rst_n), .set_i(1'b0),
      .clr_i(xfer_done), .q_o(ftu_q));

   bic_ctrl_reg #(
      .W(CTRL_W), .SET_ONLY_MASK(SET_ONLY_MASK), .X4_BIT(CT_X4)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .wdata_i(ctrl_wdata),
      .hw_clr_i(hw_clr), .brk_trail_i(brk_trail), .q_o(ctrl_byte));

   always_comb begin
      live         = '0;
      live[ST_BRK] = brk_q;
      live[ST_ERR] = err_q;
      live[ST_CRC] = crc_q;
      live[ST_X4]  = ctrl_byte[CT_X4];
      live[ST_FTU] = ftu_q;
   end

   bic_stat_snap #(.W(STAT_W), .SNAPSHOT(SNAPSHOT)) u_snap (
      .clk(clk), .rst_n(rst_n), .start_i(xfer_start),
      .live_i(live), .stat_o(stat_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_4x <= 1'b0;
      else if (brk_trail) mode_4x <= 1'b0;
      else if (bus_edge)  mode_4x <= ctrl_byte[CT_X4];
   end
endmodule

// File: rtl/bic_stat_ctrl_chk.sv
module bic_stat_ctrl_chk #(
   parameter logic [7:0] SET_ONLY_MASK = 8'hF0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_crc_err,
   input logic       xfer_start,
   input logic       xfer_done,
   input logic       brk_trail,
   input logic       bus_edge,
   input logic [7:0] hw_clr,
   input logic [7:0] stat_byte,
   input logic [7:0] ctrl_byte,
   input logic       mode_4x,
   input logic       crc_q
);
   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[7:5] == 3'b000);

   // R3
   crc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_crc_err |=> crc_q);

   // R7
   crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && stat_byte[2] && !ev_crc_err) |=> !crc_q);

   // R6
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_start |=> $stable(stat_byte));

   // R11
   brk_x4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_trail |=> (!ctrl_byte[3] && !mode_4x));

   // R12
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_edge && !brk_trail) |=> $stable(mode_4x));

   for (genvar i = 4; i < 8; i++) begin : g_so
      if (SET_ONLY_MASK[i]) begin : g_on
         // R10
         set_only_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_byte[i] && !hw_clr[i]) |=> ctrl_byte[i]);
      end
   end
endmodule

bind bic_stat_ctrl bic_stat_ctrl_chk #(.SET_ONLY_MASK(SET_ONLY_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_crc_err(ev_crc_err), .xfer_start(xfer_start),
   .xfer_done(xfer_done), .brk_trail(brk_trail), .bus_edge(bus_edge),
   .hw_clr(hw_clr), .stat_byte(stat_byte), .ctrl_byte(ctrl_byte),
   .mode_4x(mode_4x), .crc_q(crc_q));

// File: tb/tb_bic_stat_ctrl.sv
module tb_bic_stat_ctrl;
   localparam int NS = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ev_crc_err = 1'b0;
   logic [NS-1:0] ev_err_src = '0;
   logic          ev_brk_rise = 1'b0;
   logic          brk_trail = 1'b0;
   logic          xfer_start = 1'b0;
   logic          xfer_done = 1'b0;
   logic          ctrl_wr = 1'b0;
   logic [7:0]    ctrl_wdata = '0;
   logic [7:0]    hw_clr = '0;
   logic          bus_edge = 1'b0;
   logic [7:0]    stat_byte;
   logic [7:0]    ctrl_byte;
   logic          mode_4x;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bic_stat_ctrl #(.N_ERR_SRC(NS)) dut (
      .clk(clk), .rst_n(rst_n), .ev_crc_err(ev_crc_err), .ev_err_src(ev_err_src),
      .ev_brk_rise(ev_brk_rise), .brk_trail(brk_trail), .xfer_start(xfer_start),
      .xfer_done(xfer_done), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .hw_clr(hw_clr), .bus_edge(bus_edge), .stat_byte(stat_byte),
      .ctrl_byte(ctrl_byte), .mode_4x(mode_4x));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic start_x();
      xfer_start = 1'b1; step(); xfer_start = 1'b0;
   endtask

   task automatic done_x();
      xfer_done = 1'b1; step(); xfer_done = 1'b0;
   endtask

   task automatic exchange(input logic [7:0] exp, input string req);
      start_x();
      chk(stat_byte, exp, req);
      done_x();
   endtask

   task automatic wr(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v; step(); ctrl_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk(stat_byte, 8'h00, "R13 stat");
      chk(ctrl_byte, 8'h00, "R13 ctrl");
      chk({7'd0, mode_4x}, 8'h00, "R13 mode");
   endtask

   task automatic t_first_up();
      exchange(8'h10, "R2/R1 first exchange");
      exchange(8'h00, "R2 later exchange");
   endtask

   task automatic t_crc();
      ev_crc_err = 1'b1; step(); ev_crc_err = 1'b0;
      step();
      exchange(8'h04, "R3 crc flag");
      exchange(8'h00, "R7 crc cleared");
   endtask

   task automatic t_err();
      for (int i = 0; i < NS; i++) begin
         ev_err_src = NS'(1) << i; step(); ev_err_src = '0;
         exchange(8'h02, $sformatf("R4 err src %0d", i));
      end
      exchange(8'h00, "R7 err cleared");
   endtask

   task automatic t_brk();
      ev_brk_rise = 1'b1; step(); ev_brk_rise = 1'b0;
      exchange(8'h01, "R5 break flag");
      exchange(8'h00, "R7 break cleared");
   endtask

   task automatic t_snapshot();
      start_x();
      ev_crc_err = 1'b1; step(); ev_crc_err = 1'b0;
      step();
      chk(stat_byte, 8'h00, "R6 capture holds");
      done_x();
      exchange(8'h04, "R7 late flag survives");
      exchange(8'h00, "R7 late flag cleared");
   endtask

   task automatic t_set_wins();
      ev_crc_err = 1'b1; step(); ev_crc_err = 1'b0;
      start_x();
      chk(stat_byte, 8'h04, "R8 reported");
      xfer_done = 1'b1; ev_crc_err = 1'b1; step();
      xfer_done = 1'b0; ev_crc_err = 1'b0;
      exchange(8'h04, "R8 set beats clear");
      exchange(8'h00, "R8 then clears");
   endtask

   task automatic t_ctrl_rw();
      wr(8'h0D);
      chk(ctrl_byte, 8'h0D, "R9 write low bits");
      wr(8'h02);
      chk(ctrl_byte, 8'h02, "R9 rewrite low bits");
      wr(8'h08);
      exchange(8'h08, "R11 status mirrors 4X");
      wr(8'h00);
   endtask

   task automatic t_set_only();
      wr(8'hF0);
      chk(ctrl_byte, 8'hF0, "R10 set high bits");
      wr(8'h00);
      chk(ctrl_byte, 8'hF0, "R10 zero write no effect");
      hw_clr = 8'h80; step(); hw_clr = '0;
      chk(ctrl_byte, 8'h70, "R10 hw clear");
      wr(8'h75);
      chk(ctrl_byte, 8'h75, "R10 mixed write");
      hw_clr = 8'h0F; step(); hw_clr = '0;
      chk(ctrl_byte, 8'h75, "R10 hw clear ignored on low bits");
      ctrl_wr = 1'b1; ctrl_wdata = 8'h85; hw_clr = 8'h80; step();
      ctrl_wr = 1'b0; hw_clr = '0;
      chk(ctrl_byte, 8'h75, "R10 clear beats set");
   endtask

   task automatic t_break_x4();
      wr(8'h7D);
      chk(ctrl_byte, 8'h7D, "R11 4X set");
      brk_trail = 1'b1; step(); brk_trail = 1'b0;
      chk(ctrl_byte, 8'h75, "R11 break clears 4X");
      ctrl_wr = 1'b1; ctrl_wdata = 8'h0D; brk_trail = 1'b1; step();
      ctrl_wr = 1'b0; brk_trail = 1'b0;
      chk(ctrl_byte, 8'h75, "R11 break beats write");
   endtask

   task automatic t_mode();
      wr(8'h08);
      step();
      chk({7'd0, mode_4x}, 8'h00, "R12 no edge no change");
      bus_edge = 1'b1; step(); bus_edge = 1'b0;
      chk({7'd0, mode_4x}, 8'h01, "R12 edge applies");
      wr(8'h00);
      chk({7'd0, mode_4x}, 8'h01, "R12 write alone holds");
      bus_edge = 1'b1; step(); bus_edge = 1'b0;
      chk({7'd0, mode_4x}, 8'h00, "R12 edge applies clear");
      wr(8'h08);
      bus_edge = 1'b1; step(); bus_edge = 1'b0;
      brk_trail = 1'b1; step(); brk_trail = 1'b0;
      chk({7'd0, mode_4x}, 8'h00, "R12 break clears mode");
      chk(ctrl_byte & 8'h08, 8'h00, "R11 break clears bit");
      hw_clr = 8'hF0; step(); hw_clr = '0;
      chk(ctrl_byte, 8'h00, "R10 all cleared");
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #3;
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_first_up();
      t_crc();
      t_err();
      t_brk();
      t_snapshot();
      t_set_wins();
      t_ctrl_rw();
      t_set_only();
      t_break_x4();
      t_mode();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule